// File: doc/BRIEF.md
# Random Memory Traffic Checker

This block drives pseudo-random single-byte traffic into a memory port and checks what comes back. On each free cycle it rolls a command (read or write), an address lane and a data byte from a free-running 32-bit LFSR. It sends the request over a valid/ready channel and records it in a small table of in-flight addresses. It also keeps a shadow copy of every byte it can touch. A read is checked against the shadow byte captured when the read was generated. A write updates the shadow only when its completion returns.

Several copies of the block can share one memory for false-sharing stress. Each copy owns one byte lane inside every block, chosen by `TESTER_ID`, so the copies touch neighbouring bytes of the same blocks without overlapping. The status outputs report a data mismatch, a stalled memory (no completion within a cycle limit), reaching a read budget, and a one-cycle pulse at every read milestone. `MEM_BYTES` and `BLOCK_BYTES` are powers of two, with `BLOCK_BYTES` smaller than `MEM_BYTES`.

Top module: `rmt_traffic_checker`

## Requirements
- R1: While and just after reset, `req_valid`, `mismatch`, `deadlock`, `done` and `progress` are 0, and the shadow copy holds zero in every byte.
- R2: A generated request is a read when a draw modulo 100 is below `read_pct`, and a write otherwise. With `read_pct` = 0 every request is a write (`req_write` = 1). With `read_pct` = 100 every request is a read.
- R3: A request is uncacheable when a separate draw modulo 100 is below `uncached_pct`. Such a request has `req_uncached` = 1 and an address in 0x800000 + [0, `MEM_BYTES`). With `uncached_pct` = 0 no request is uncacheable, and with 100 every request is.
- R4: A cacheable request has `req_uncached` = 0 and an address in 0x100000 + [0, `MEM_BYTES`) or 0x400000 + [0, `MEM_BYTES`). On every request, the address modulo `BLOCK_BYTES` equals `TESTER_ID`.
- R5: No address is requested again while an earlier request to it is in flight. A candidate whose address is in flight is dropped for that cycle. At most `INFLIGHT` requests, counting the one being held, are in flight at once.
- R6: While `req_valid` is 1 and `req_ready` is 0, the request fields stay unchanged and no other request is issued.
- R7: A read completion without error whose `rsp_data` differs from the expected byte sets `mismatch` at the next edge. The flag stays set until reset.
- R8: The shadow byte for an address takes the write data when the write's completion arrives. Reads of bytes never written expect zero.
- R9: A completion with `rsp_error` = 1 skips the read comparison and the shadow update, but still frees its address for new requests.
- R10: `deadlock` becomes 1 when `DEADLOCK_LIMIT` edges have passed since the last completion edge without another completion. It stays 1 until reset.
- R11: `done` becomes 1 at the edge where error-free read completions reach a nonzero `MAX_READS`. From then on no new request is generated.
- R12: `progress` pulses for one cycle at the edge where the count of error-free read completions reaches each multiple of `PROGRESS_EVERY`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| read_pct | input | 7 | Read share in percent (0..100) |
| uncached_pct | input | 7 | Uncacheable share in percent (0..100) |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Memory accepts the request this cycle |
| req_write | output | 1 | 1 = write, 0 = read |
| req_uncached | output | 1 | Request bypasses caches |
| req_addr | output | 24 | Byte address |
| req_data | output | 8 | Write byte (0 for reads) |
| rsp_valid | input | 1 | Completion present |
| rsp_addr | input | 24 | Address of the completed request |
| rsp_data | input | 8 | Read data returned |
| rsp_error | input | 1 | Completion failed |
| mismatch | output | 1 | Sticky read-data error |
| deadlock | output | 1 | Sticky no-completion timeout |
| done | output | 1 | Read budget reached |
| progress | output | 1 | One-cycle read-milestone pulse |

## Verification
A corrupted shadow byte or a misapplied write is not visible at once. It shows at the ports only when a later read of that lane completes and raises `mismatch` one edge after the completion. The bench therefore runs long mixed phases and follows error-response phases with clean traffic, so that a stale or wrongly updated byte gets read back. A stale in-flight table entry shows up in one of two ways: the same address is issued twice, which the bench catches at acceptance, or the generator stops issuing, which holds back completions and raises `deadlock` after exactly `DEADLOCK_LIMIT` edges. Counter faults show up at the exact edge where `done` or `progress` is expected.

// File: rtl/rmt_pkg.sv
package rmt_pkg;

    localparam int ADDR_W = 24;

    localparam logic [ADDR_W-1:0] BASE_A = 24'h100000;
    localparam logic [ADDR_W-1:0] BASE_B = 24'h400000;
    localparam logic [ADDR_W-1:0] BASE_U = 24'h800000;

    // region code also forms the top bits of the shadow index
    typedef enum logic [1:0] {
        REG_A = 2'd0,
        REG_B = 2'd1,
        REG_U = 2'd2
    } region_e;

    typedef struct packed {
        logic              write;
        logic              uncached;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } mreq_t;

    // Galois step, polynomial x^32 + x^22 + x^2 + x + 1
    function automatic logic [31:0] lfsr_step(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
    endfunction

    function automatic logic [ADDR_W-1:0] region_base(input region_e r);
        case (r)
            REG_A:   return BASE_A;
            REG_B:   return BASE_B;
            default: return BASE_U;
        endcase
    endfunction

endpackage

// File: rtl/rmt_lfsr.sv
module rmt_lfsr #(
    parameter logic [31:0] SEED = 32'h1ACE_B00C
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] state
);
    import rmt_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) state <= (SEED == 32'h0) ? 32'h1 : SEED;
        else     state <= lfsr_step(state);
    end
endmodule

// File: rtl/rmt_inflight.sv
module rmt_inflight #(
    parameter int DEPTH = 4,
    parameter int AW    = 24,
    parameter int IW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] probe_addr,
    output logic          probe_hit,
    output logic          full,
    input  logic          alloc,
    input  logic          alloc_write,
    input  logic [IW-1:0] alloc_idx,
    input  logic [7:0]    alloc_byte,
    input  logic          rel_req,
    input  logic [AW-1:0] rel_addr,
    output logic          rel_hit,
    output logic          rel_write,
    output logic [IW-1:0] rel_idx,
    output logic [7:0]    rel_byte
);
    logic          busy   [DEPTH];
    logic [AW-1:0] e_addr [DEPTH];
    logic          e_wr   [DEPTH];
    logic [IW-1:0] e_idx  [DEPTH];
    logic [7:0]    e_byte [DEPTH];

    logic [DEPTH-1:0] busy_v, probe_m, rel_m, slot_oh;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            assign busy_v[g]  = busy[g];
            assign probe_m[g] = busy[g] && (e_addr[g] == probe_addr);
            assign rel_m[g]   = busy[g] && (e_addr[g] == rel_addr);

            always_ff @(posedge clk) begin
                if (rst) begin
                    busy[g]   <= 1'b0;
                    e_addr[g] <= '0;
                    e_wr[g]   <= 1'b0;
                    e_idx[g]  <= '0;
                    e_byte[g] <= '0;
                end else begin
                    if (rel_req && rel_m[g]) busy[g] <= 1'b0;
                    if (alloc && slot_oh[g]) begin
                        busy[g]   <= 1'b1;
                        e_addr[g] <= probe_addr;
                        e_wr[g]   <= alloc_write;
                        e_idx[g]  <= alloc_idx;
                        e_byte[g] <= alloc_byte;
                    end
                end
            end
        end
    endgenerate

    // lowest free slot wins
    always_comb begin
        slot_oh = '0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (!busy[i]) slot_oh = DEPTH'(1) << i;
    end

    always_comb begin
        rel_write = 1'b0;
        rel_idx   = '0;
        rel_byte  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rel_m[i]) begin
                rel_write = rel_write | e_wr[i];
                rel_idx   = rel_idx   | e_idx[i];
                rel_byte  = rel_byte  | e_byte[i];
            end
        end
    end

    assign probe_hit = |probe_m;
    assign full      = &busy_v;
    assign rel_hit   = rel_req && (|rel_m);
endmodule

// File: rtl/rmt_watch.sv
module rmt_watch #(
    parameter int LIMIT      = 500000,
    parameter int MAX_READS  = 0,
    parameter int PROG_EVERY = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic complete,
    input  logic good_read,
    output logic deadlock,
    output logic done,
    output logic progress
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam int PW = $clog2((PROG_EVERY > 1) ? PROG_EVERY : 2);

    logic [CW-1:0] idle_q, idle_d;
    logic [31:0]   reads_q;
    logic [PW-1:0] prog_q;

    always_comb begin
        if (complete)                 idle_d = '0;
        else if (idle_q == CW'(LIMIT)) idle_d = idle_q;
        else                          idle_d = idle_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q   <= '0;
            reads_q  <= '0;
            prog_q   <= '0;
            deadlock <= 1'b0;
            done     <= 1'b0;
            progress <= 1'b0;
        end else begin
            idle_q   <= idle_d;
            deadlock <= deadlock | (idle_d == CW'(LIMIT));
            progress <= 1'b0;
            if (good_read) begin
                reads_q <= reads_q + 32'd1;
                if (prog_q == PW'(PROG_EVERY - 1)) begin
                    prog_q   <= '0;
                    progress <= 1'b1;
                end else begin
                    prog_q <= prog_q + 1'b1;
                end
                if (MAX_READS != 0 && (reads_q + 32'd1) >= 32'(MAX_READS))
                    done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rmt_traffic_checker.sv
module rmt_traffic_checker
    import rmt_pkg::*;
#(
    parameter int          TESTER_ID      = 0,
    parameter int          BLOCK_BYTES    = 16,
    parameter int          MEM_BYTES      = 64,
    parameter int          INFLIGHT       = 4,
    parameter int          DEADLOCK_LIMIT = 500000,
    parameter int          MAX_READS      = 0,
    parameter int          PROGRESS_EVERY = 1000,
    parameter logic [31:0] SEED           = 32'h1ACE_B00C
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [6:0]  read_pct,
    input  logic [6:0]  uncached_pct,
    output logic        req_valid,
    input  logic        req_ready,
    output logic        req_write,
    output logic        req_uncached,
    output logic [23:0] req_addr,
    output logic [7:0]  req_data,
    input  logic        rsp_valid,
    input  logic [23:0] rsp_addr,
    input  logic [7:0]  rsp_data,
    input  logic        rsp_error,
    output logic        mismatch,
    output logic        deadlock,
    output logic        done,
    output logic        progress
);
    localparam int OFF_W    = $clog2(MEM_BYTES);
    localparam int BLK_W    = $clog2(BLOCK_BYTES);
    localparam int IDX_W    = OFF_W + 2;
    localparam int SHADOW_N = 1 << IDX_W;

    // ---------------- random draws ----------------
    logic [31:0] rnd;
    rmt_lfsr #(.SEED(SEED)) u_rng (.clk(clk), .rst(rst), .state(rnd));

    logic [9:0]        cmd_roll, unc_roll;
    logic              want_read, want_unc;
    region_e           reg_sel;
    logic [OFF_W-1:0]  off_raw, off_lane;
    logic [ADDR_W-1:0] cand_addr;
    logic [IDX_W-1:0]  cand_idx;
    logic [7:0]        cand_wdata;

    always_comb begin
        cmd_roll   = rnd[9:0]   % 10'd100;
        unc_roll   = rnd[19:10] % 10'd100;
        want_read  = cmd_roll < {3'b000, read_pct};
        want_unc   = unc_roll < {3'b000, uncached_pct};
        reg_sel    = want_unc ? REG_U : (rnd[20] ? REG_A : REG_B);
        off_raw    = OFF_W'(32'(rnd[31:16]) % MEM_BYTES);
        off_lane   = {off_raw[OFF_W-1:BLK_W], BLK_W'(TESTER_ID)};
        cand_addr  = region_base(reg_sel) + ADDR_W'(off_lane);
        cand_idx   = {reg_sel, off_lane};
        cand_wdata = rnd[31:24] ^ rnd[7:0];
    end

    // ---------------- in-flight table ----------------
    logic             probe_hit, table_full, gen_go;
    logic             rel_hit, rel_write;
    logic [IDX_W-1:0] rel_idx;
    logic [7:0]       rel_byte, alloc_byte;
    logic [7:0]       shadow [SHADOW_N];
    logic             req_live;
    mreq_t            req_q;

    assign gen_go     = !req_live && !done && !probe_hit && !table_full;
    assign alloc_byte = want_read ? shadow[cand_idx] : cand_wdata;

    rmt_inflight #(.DEPTH(INFLIGHT), .AW(ADDR_W), .IW(IDX_W)) u_tbl (
        .clk(clk), .rst(rst),
        .probe_addr(cand_addr), .probe_hit(probe_hit), .full(table_full),
        .alloc(gen_go), .alloc_write(!want_read), .alloc_idx(cand_idx),
        .alloc_byte(alloc_byte),
        .rel_req(rsp_valid), .rel_addr(rsp_addr),
        .rel_hit(rel_hit), .rel_write(rel_write), .rel_idx(rel_idx),
        .rel_byte(rel_byte)
    );

    // ---------------- request holding register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            req_live <= 1'b0;
            req_q    <= '0;
        end else if (gen_go) begin
            req_live       <= 1'b1;
            req_q.write    <= !want_read;
            req_q.uncached <= want_unc;
            req_q.addr     <= cand_addr;
            req_q.data     <= want_read ? 8'h00 : cand_wdata;
        end else if (req_live && req_ready) begin
            req_live <= 1'b0;
        end
    end

    assign req_valid    = req_live;
    assign req_write    = req_q.write;
    assign req_uncached = req_q.uncached;
    assign req_addr     = req_q.addr;
    assign req_data     = req_q.data;

    // ---------------- completion handling ----------------
    logic good_cpl, shadow_we, good_read, chk_fail;
    assign good_cpl  = rel_hit && !rsp_error;
    assign shadow_we = good_cpl && rel_write;
    assign good_read = good_cpl && !rel_write;
    assign chk_fail  = good_read && (rsp_data != rel_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SHADOW_N; i++) shadow[i] <= 8'h00;
        end else if (shadow_we) begin
            shadow[rel_idx] <= rel_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           mismatch <= 1'b0;
        else if (chk_fail) mismatch <= 1'b1;
    end

    rmt_watch #(
        .LIMIT(DEADLOCK_LIMIT), .MAX_READS(MAX_READS), .PROG_EVERY(PROGRESS_EVERY)
    ) u_watch (
        .clk(clk), .rst(rst), .complete(rel_hit), .good_read(good_read),
        .deadlock(deadlock), .done(done), .progress(progress)
    );
endmodule

// File: rtl/rmt_traffic_checker_sva.sv
module rmt_traffic_checker_sva #(
    parameter int TESTER_ID   = 0,
    parameter int BLOCK_BYTES = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic        req_uncached,
    input logic [23:0] req_addr,
    input logic [7:0]  req_data,
    input logic        mismatch,
    input logic        deadlock,
    input logic        done
);
    localparam int BLK_W = $clog2(BLOCK_BYTES);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data)
                                    && $stable(req_write) && $stable(req_uncached));

    p_lane_r4: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_addr[BLK_W-1:0] == BLK_W'(TESTER_ID));

    p_unc_region_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_uncached == (req_addr >= 24'h800000)));

    p_mismatch_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        mismatch |=> mismatch);

    p_deadlock_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        deadlock |=> deadlock);

    p_done_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        done && !req_valid |=> !req_valid);
endmodule

bind rmt_traffic_checker rmt_traffic_checker_sva #(
    .TESTER_ID(TESTER_ID), .BLOCK_BYTES(BLOCK_BYTES)
) u_sva (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_uncached(req_uncached), .req_addr(req_addr),
    .req_data(req_data), .mismatch(mismatch), .deadlock(deadlock), .done(done)
);

// File: tb/rmt_traffic_checker_test.sv
module rmt_traffic_checker_test;
    localparam int ID    = 5;
    localparam int BLK   = 16;
    localparam int MEM   = 64;
    localparam int DEPTH = 4;
    localparam int LIMIT = 300;
    localparam int MAXR  = 400;
    localparam int PROG  = 16;

    // stimulus table: read share, uncached share
    localparam int VEC_RP [4] = '{50, 0, 100, 30};
    localparam int VEC_UP [4] = '{20, 0, 0, 100};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic [6:0]  read_pct = 7'd50, uncached_pct = 7'd0;
    logic        req_valid, req_write, req_uncached;
    logic        req_ready = 1'b0;
    logic [23:0] req_addr;
    logic [7:0]  req_data;
    logic        rsp_valid = 1'b0, rsp_error = 1'b0;
    logic [23:0] rsp_addr = '0;
    logic [7:0]  rsp_data = '0;
    logic        mismatch, deadlock, done, progress;

    rmt_traffic_checker #(
        .TESTER_ID(ID), .BLOCK_BYTES(BLK), .MEM_BYTES(MEM), .INFLIGHT(DEPTH),
        .DEADLOCK_LIMIT(LIMIT), .MAX_READS(MAXR), .PROGRESS_EVERY(PROG)
    ) uut (
        .clk(clk), .rst(rst), .read_pct(read_pct), .uncached_pct(uncached_pct),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_uncached(req_uncached), .req_addr(req_addr), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
        .rsp_error(rsp_error), .mismatch(mismatch), .deadlock(deadlock),
        .done(done), .progress(progress)
    );

    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    typedef struct {
        logic [23:0] addr;
        logic        wr;
        logic [7:0]  data;
    } pend_t;

    pend_t      pq [$];
    logic [7:0] model [int];

    bit stall = 0, hold_rsp = 0, err_rsp = 0, corrupt_next = 0, expect_clean = 1;
    bit exp_prog = 0;
    int cyc = 0, last_rsp_cyc = 0, good_reads = 0;
    int st_rd, st_wr, st_unc, st_cac, st_bad, st_dup, st_flag, st_perr, st_derr;
    int st_acc, st_over, st_pulses;
    logic [23:0] acc_addr;

    function automatic bit addr_ok(input logic [23:0] a, input logic u);
        int base;
        int off;
        base = u ? 'h800000 : ((a >= 24'h400000) ? 'h400000 : 'h100000);
        off  = int'(a) - base;
        return (off >= 0) && (off < MEM) && ((int'(a) % BLK) == ID);
    endfunction

    task automatic clear_stats();
        st_rd = 0; st_wr = 0; st_unc = 0; st_cac = 0; st_bad = 0; st_dup = 0;
        st_flag = 0; st_perr = 0; st_derr = 0; st_acc = 0; st_over = 0; st_pulses = 0;
    endtask

    task automatic step();
        pend_t      p;
        logic [7:0] rv;
        @(negedge clk);
        cyc++;
        if (!rst) begin
            if (progress !== exp_prog) st_perr++;
            if (progress) st_pulses++;
            if (done !== (good_reads >= MAXR)) st_derr++;
            if (expect_clean && (mismatch || deadlock)) st_flag++;
            if (pq.size() > DEPTH) st_over++;
        end
        rsp_valid = 1'b0; rsp_error = 1'b0; rsp_addr = '0; rsp_data = '0;
        exp_prog  = 1'b0;
        req_ready = !rst && !stall;
        if (req_valid && req_ready) begin
            st_acc++;
            acc_addr = req_addr;
            if (!addr_ok(req_addr, req_uncached)) st_bad++;
            foreach (pq[i]) if (pq[i].addr == req_addr) st_dup++;
            if (req_write) st_wr++; else st_rd++;
            if (req_uncached) st_unc++; else st_cac++;
        end
        if (!rst && !hold_rsp && pq.size() > 0 && $urandom_range(1, 0) == 1) begin
            p = pq.pop_front();
            rsp_valid = 1'b1; rsp_addr = p.addr; rsp_error = err_rsp;
            last_rsp_cyc = cyc;
            if (p.wr) begin
                if (!err_rsp) model[int'(p.addr)] = p.data;
            end else begin
                rv = model.exists(int'(p.addr)) ? model[int'(p.addr)] : 8'h00;
                if (err_rsp) begin
                    rsp_data = ~rv;
                end else begin
                    rsp_data = rv;
                    if (corrupt_next) begin
                        rsp_data = rv ^ 8'h01;
                        corrupt_next = 0;
                    end
                    good_reads++;
                    exp_prog = (good_reads % PROG) == 0;
                end
            end
        end
        if (req_valid && req_ready) begin
            p.addr = req_addr; p.wr = req_write; p.data = req_data;
            pq.push_back(p);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        pq.delete(); model.delete();
        good_reads = 0; exp_prog = 0; stall = 0; hold_rsp = 0; err_rsp = 0;
        corrupt_next = 0; expect_clean = 1;
        repeat (3) step();
        rst = 1'b0;
        clear_stats();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        report();
        $finish;
    end

    initial begin
        logic [23:0] h_addr;
        logic [7:0]  h_data;
        logic        h_wr;
        int          moved;

        // R1: reset state
        do_reset();
        check(req_valid == 0 && mismatch == 0 && deadlock == 0 && done == 0 && progress == 0,
              "R1 outputs after reset", {req_valid, mismatch, deadlock, done, progress}, 0);

        // table-driven mixed traffic
        for (int v = 0; v < 4; v++) begin
            do_reset();
            read_pct = 7'(VEC_RP[v]); uncached_pct = 7'(VEC_UP[v]);
            repeat (400) step();
            check(st_bad == 0, "R4 address lane/region", st_bad, 0);
            check(st_dup == 0 && st_over == 0, "R5 one in flight per address", st_dup + st_over, 0);
            check(st_acc > DEPTH, "R5 addresses recycled", st_acc, DEPTH + 1);
            if (VEC_RP[v] == 0)        check(st_rd == 0 && st_wr > 0, "R2 all writes", st_rd, 0);
            else if (VEC_RP[v] == 100) check(st_wr == 0 && st_rd > 0, "R2 all reads", st_wr, 0);
            else                       check(st_wr > 0 && st_rd > 0, "R2 mixed", st_rd, 1);
            if (VEC_UP[v] == 100)    check(st_cac == 0 && st_unc > 0, "R3 all uncached", st_cac, 0);
            else if (VEC_UP[v] == 0) check(st_unc == 0, "R3 none uncached", st_unc, 0);
            else                     check(st_unc > 0 && st_cac > 0, "R3 mixed", st_unc, 1);
            check(st_flag == 0, "R7 R8 R10 no flag on clean traffic", st_flag, 0);
            check(st_perr == 0, "R12 progress pulses", st_perr, 0);
            check(st_derr == 0, "R11 done low below budget", st_derr, 0);
        end

        // R6: held request under back-pressure
        do_reset();
        read_pct = 7'd50; uncached_pct = 7'd10;
        repeat (20) step();
        stall = 1;
        step();
        while (!req_valid) step();
        h_addr = req_addr; h_data = req_data; h_wr = req_write;
        moved = 0;
        st_acc = 0;
        repeat (10) begin
            step();
            if (!req_valid || req_addr != h_addr || req_data != h_data || req_write != h_wr) moved++;
        end
        check(moved == 0 && st_acc == 0, "R6 request held while not ready", moved, 0);
        stall = 0;
        step();
        check(st_acc == 1 && acc_addr == h_addr, "R6 held request sent unchanged", acc_addr, h_addr);

        // R9: error completions
        do_reset();
        read_pct = 7'd50; uncached_pct = 7'd0;
        err_rsp = 1;
        repeat (300) step();
        check(st_acc > 4 * DEPTH, "R9 error completion frees address", st_acc, 4 * DEPTH + 1);
        check(mismatch == 0, "R9 error read not compared", mismatch, 0);
        check(st_pulses == 0 && good_reads == 0, "R9 error reads not counted", st_pulses, 0);
        err_rsp = 0;
        repeat (500) step();
        check(mismatch == 0 && st_flag == 0, "R9 R8 shadow untouched by error writes", mismatch, 0);

        // R7: corrupted read data
        do_reset();
        read_pct = 7'd100; uncached_pct = 7'd0;
        expect_clean = 0;
        repeat (20) step();
        corrupt_next = 1;
        while (corrupt_next) step();
        check(mismatch == 0, "R7 mismatch low before bad completion edge", mismatch, 0);
        step();
        check(mismatch == 1, "R7 mismatch set after bad read", mismatch, 1);
        repeat (5) step();
        check(mismatch == 1, "R7 mismatch sticky", mismatch, 1);
        do_reset();
        check(mismatch == 0 && req_valid == 0, "R1 reset clears sticky mismatch", mismatch, 0);

        // R10: stop completing
        read_pct = 7'd50; uncached_pct = 7'd0;
        expect_clean = 0;
        repeat (50) step();
        hold_rsp = 1;
        step();
        while (cyc < last_rsp_cyc + LIMIT) step();
        check(deadlock == 0, "R10 deadlock low one edge early", deadlock, 0);
        check(pq.size() == DEPTH && req_valid == 0, "R5 issue stops when table full",
              pq.size(), DEPTH);
        step();
        check(deadlock == 1, "R10 deadlock at limit", deadlock, 1);
        repeat (5) step();
        check(deadlock == 1, "R10 deadlock sticky", deadlock, 1);

        // R11 / R12: read budget and milestones
        do_reset();
        read_pct = 7'd100; uncached_pct = 7'd30;
        for (int k = 0; k < 4000 && !done; k++) step();
        check(done == 1 && good_reads >= MAXR, "R11 done at read budget", good_reads, MAXR);
        check(st_derr == 0, "R11 done edge exact", st_derr, 0);
        check(st_perr == 0 && st_pulses == good_reads / PROG, "R12 milestone pulses",
              st_pulses, good_reads / PROG);
        repeat (10) step();
        st_acc = 0;
        repeat (20) step();
        check(st_acc == 0 && req_valid == 0, "R11 no requests after done", st_acc, 0);

        report();
        $finish;
    end
endmodule